// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block decides which of several loaded transmit buffers is handed to the CAN protocol engine next. It also keeps the control and status flags of each buffer current. Software marks a buffer as pending by writing its request bit together with a 2-bit priority. A buffer can also be marked pending by a falling edge on its active-low request pin, when that pin's function is enabled. Each time the protocol engine signals that the bus is free, the scheduler compares the priorities of all pending buffers and launches the best one.

The engine then reports one outcome for the launched buffer: success, lost arbitration or error. The scheduler updates the request bit and the flags of that buffer. It also raises the per-buffer transmit-done flags and the shared message-error flag, which are gated by enable bits into a single interrupt line. Two controls change how failures and pending work are handled. A one-shot enable limits every buffer to a single attempt. A global abort level clears every waiting request, and the message already on the bus is dropped only if it fails.

Top module: `txs_sched`

## Requirements
- R1: At a launch the pending buffer with the numerically largest priority value is chosen (3 highest, 0 lowest), and `start_o` pulses high for one cycle with `start_idx_o` holding that buffer index, in the cycle after the `bus_idle` strobe.
- R2: Among pending buffers of equal priority, the one with the larger index is launched.
- R3: A launch happens only on a `bus_idle` strobe while no attempt is in flight, `abort_all` is low and at least one request bit is set. `busy_o` stays high from the launch until an outcome strobe.
- R4: A write with `wr_req`=1, or a falling edge on `rts_n[i]` while `rts_en[i]`=1, sets request bit i and clears that buffer's abort, arbitration-lost and error flags. An edge on a pin whose `rts_en` is 0 leaves the request bit unchanged.
- R5: On `tx_ok` the active buffer's request bit clears and its done flag `done_o[i]` sets.
- R6: On `tx_lost` the active buffer's `mloa_o` bit sets and its request bit stays set, so that buffer competes again at the next launch on priority.
- R7: On `tx_err` the active buffer's `txerr_o` bit and the shared `merr_o` flag set, and the request bit stays set. When several outcome strobes come together, success beats error and error beats arbitration loss.
- R8: With `one_shot`=1, a failed attempt (lost or error) clears the request bit and sets that buffer's `abtf_o` bit. A successful attempt behaves as in R5.
- R9: While `abort_all`=1, every pending buffer that is not in flight has its request bit cleared and its abort flag set. The buffer in flight is aborted the same way only if its outcome is a failure.
- R10: A write with `wr_req`=0 clears the request bit without setting the abort flag.
- R11: `done_clr[i]` and `merr_clr` clear their flags, and clearing wins over setting in the same cycle. `irq_o` is high exactly when some done flag or `merr_o` is set together with its enable bit.
- R12: After reset all request bits, flags, `busy_o`, `start_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | NBUF | Per-buffer control write strobe |
| wr_req | input | NBUF | Request bit value written |
| wr_prio | input | NBUF*PW | Priority value written, buffer i at bits [i*PW +: PW] |
| rts_n | input | NBUF | Active-low request pins |
| rts_en | input | NBUF | Enables the request function of each pin |
| abort_all | input | 1 | Global abort level |
| one_shot | input | 1 | Single attempt per request |
| bus_idle | input | 1 | Engine strobe: bus free for a new frame |
| tx_ok | input | 1 | Outcome strobe: frame sent |
| tx_lost | input | 1 | Outcome strobe: arbitration lost |
| tx_err | input | 1 | Outcome strobe: error during frame |
| done_clr | input | NBUF | Clears the done flags |
| merr_clr | input | 1 | Clears the message-error flag |
| done_ie | input | NBUF | Done interrupt enables |
| merr_ie | input | 1 | Message-error interrupt enable |
| start_o | output | 1 | One-cycle launch pulse |
| start_idx_o | output | IW | Index of the launched buffer |
| busy_o | output | 1 | An attempt is in flight |
| req_o | output | NBUF | Request bits |
| abtf_o | output | NBUF | Abort flags |
| mloa_o | output | NBUF | Arbitration-lost flags |
| txerr_o | output | NBUF | Transmit-error flags |
| done_o | output | NBUF | Transmit-done flags |
| merr_o | output | 1 | Shared message-error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong choice in the arbiter shows at `start_idx_o` in the cycle after `bus_idle`. A request bit left set or cleared in error shows on `req_o` one cycle after the stimulus. It shows again at the next launch, where a retried or aborted buffer is picked or skipped. Flag faults appear on the flag outputs in the cycle after an outcome strobe, and through `irq_o` in the same cycle once enables are set. A stale `busy_o` shows up as a missing launch on the next strobe.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_OK   = 2'd1,
    OUT_LOST = 2'd2,
    OUT_ERR  = 2'd3
  } outc_t;

  // success beats error, error beats arbitration loss
  function automatic outc_t decode_outc(input logic ok, input logic lost, input logic err);
    if (ok)        return OUT_OK;
    else if (err)  return OUT_ERR;
    else if (lost) return OUT_LOST;
    else           return OUT_NONE;
  endfunction
endpackage

// File: rtl/txs_pick.sv
module txs_pick #(
  parameter int NBUF = 3,
  parameter int PW   = 2,
  parameter int IW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF-1:0]    req,
  input  logic [NBUF*PW-1:0] prio,
  output logic [IW-1:0]      win,
  output logic               any
);
  // ascending scan with >= : a later index takes equal priority
  function automatic logic [IW:0] pick(input logic [NBUF-1:0] r, input logic [NBUF*PW-1:0] p);
    logic [PW-1:0] best;
    logic [IW-1:0] idx;
    logic          fnd;
    best = '0; idx = '0; fnd = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (r[i] && (!fnd || p[i*PW +: PW] >= best)) begin
        best = p[i*PW +: PW];
        idx  = IW'(i);
        fnd  = 1'b1;
      end
    end
    return {fnd, idx};
  endfunction

  assign {any, win} = pick(req, prio);

  always_comb begin
    for (int j = 0; j < NBUF; j++) begin
      if (any && req[j]) begin
        // R1
        prio_order_chk: assert (prio[j*PW +: PW] <= prio[int'(win)*PW +: PW]);
        // R2
        tie_high_chk: assert (prio[j*PW +: PW] != prio[int'(win)*PW +: PW] || j <= int'(win));
      end
    end
  end
endmodule

// File: rtl/txs_slot.sv
module txs_slot
  import txs_pkg::*;
#(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_req,
  input  logic [PW-1:0] wr_prio,
  input  logic          rts_hit,
  input  logic          act_sel,
  input  outc_t         outc,
  input  logic          one_shot,
  input  logic          abort_all,
  input  logic          done_clr,
  output logic          req_o,
  output logic [PW-1:0] prio_o,
  output logic          abtf_o,
  output logic          mloa_o,
  output logic          txerr_o,
  output logic          done_o
);
  logic req_q, abtf_q, mloa_q, txerr_q, done_q;
  logic [PW-1:0] prio_q;

  // named events for the assertions
  logic ok_hit, fail_hit, set_ev, drop_ev;
  assign ok_hit   = act_sel && (outc == OUT_OK);
  assign fail_hit = act_sel && (outc == OUT_LOST || outc == OUT_ERR);
  assign set_ev   = (wr_en && wr_req) || rts_hit;
  assign drop_ev  = abort_all && req_q && !act_sel;

  logic req_n, abtf_n, mloa_n, txerr_n, done_n;
  logic [PW-1:0] prio_n;

  always_comb begin
    req_n = req_q; abtf_n = abtf_q; mloa_n = mloa_q;
    txerr_n = txerr_q; done_n = done_q; prio_n = prio_q;
    if (ok_hit) begin
      req_n  = 1'b0;
      done_n = 1'b1;
    end
    if (fail_hit) begin
      if (outc == OUT_LOST) mloa_n = 1'b1;
      else                  txerr_n = 1'b1;
      if (one_shot || abort_all) begin
        req_n  = 1'b0;
        abtf_n = 1'b1;
      end
    end
    if (drop_ev) begin
      req_n  = 1'b0;
      abtf_n = 1'b1;
    end
    if (wr_en) begin
      req_n  = wr_req;
      prio_n = wr_prio;
    end
    if (rts_hit) req_n = 1'b1;
    if (set_ev) begin
      abtf_n = 1'b0; mloa_n = 1'b0; txerr_n = 1'b0;
    end
    if (done_clr) done_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0; abtf_q <= 1'b0; mloa_q <= 1'b0;
      txerr_q <= 1'b0; done_q <= 1'b0; prio_q <= '0;
    end else begin
      req_q <= req_n; abtf_q <= abtf_n; mloa_q <= mloa_n;
      txerr_q <= txerr_n; done_q <= done_n; prio_q <= prio_n;
    end
  end

  assign req_o = req_q;   assign prio_o = prio_q;  assign abtf_o = abtf_q;
  assign mloa_o = mloa_q; assign txerr_o = txerr_q; assign done_o = done_q;

  // R5
  ok_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_hit && !set_ev && !done_clr |=> !req_q && done_q);
  // R4
  set_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev && !fail_hit |=> req_q && !abtf_q && !mloa_q && !txerr_q);
  // R8
  oneshot_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_hit && one_shot && !set_ev |=> !req_q && abtf_q);
  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev && !set_ev |=> !req_q && abtf_q);
endmodule

// File: rtl/txs_sched.sv
module txs_sched
  import txs_pkg::*;
#(
  parameter int NBUF = 3,
  parameter int PW   = 2,
  parameter int IW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBUF-1:0]    wr_en,
  input  logic [NBUF-1:0]    wr_req,
  input  logic [NBUF*PW-1:0] wr_prio,
  input  logic [NBUF-1:0]    rts_n,
  input  logic [NBUF-1:0]    rts_en,
  input  logic               abort_all,
  input  logic               one_shot,
  input  logic               bus_idle,
  input  logic               tx_ok,
  input  logic               tx_lost,
  input  logic               tx_err,
  input  logic [NBUF-1:0]    done_clr,
  input  logic               merr_clr,
  input  logic [NBUF-1:0]    done_ie,
  input  logic               merr_ie,
  output logic               start_o,
  output logic [IW-1:0]      start_idx_o,
  output logic               busy_o,
  output logic [NBUF-1:0]    req_o,
  output logic [NBUF-1:0]    abtf_o,
  output logic [NBUF-1:0]    mloa_o,
  output logic [NBUF-1:0]    txerr_o,
  output logic [NBUF-1:0]    done_o,
  output logic               merr_o,
  output logic               irq_o
);
  logic [NBUF-1:0]    rts_prev_q, rts_fall;
  logic [NBUF*PW-1:0] prio_flat;
  logic [IW-1:0]      win, act_q, idx_q;
  logic               any, launch, busy_q, start_q, merr_q;
  outc_t              outc;

  assign rts_fall = rts_en & rts_prev_q & ~rts_n;
  assign outc     = busy_q ? decode_outc(tx_ok, tx_lost, tx_err) : OUT_NONE;

  txs_pick #(.NBUF(NBUF), .PW(PW), .IW(IW)) u_pick (
    .req(req_o), .prio(prio_flat), .win(win), .any(any)
  );

  assign launch = bus_idle && !busy_q && !abort_all && any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_prev_q <= '1;
      busy_q <= 1'b0; start_q <= 1'b0; act_q <= '0; idx_q <= '0; merr_q <= 1'b0;
    end else begin
      rts_prev_q <= rts_n;
      start_q    <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        act_q  <= win;
        idx_q  <= win;
      end else if (outc != OUT_NONE) begin
        busy_q <= 1'b0;
      end
      if (outc == OUT_ERR) merr_q <= 1'b1;
      if (merr_clr)        merr_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    txs_slot #(.PW(PW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[i]), .wr_req(wr_req[i]), .wr_prio(wr_prio[i*PW +: PW]),
      .rts_hit(rts_fall[i]),
      .act_sel(busy_q && act_q == IW'(i)),
      .outc(outc), .one_shot(one_shot), .abort_all(abort_all),
      .done_clr(done_clr[i]),
      .req_o(req_o[i]), .prio_o(prio_flat[i*PW +: PW]),
      .abtf_o(abtf_o[i]), .mloa_o(mloa_o[i]), .txerr_o(txerr_o[i]), .done_o(done_o[i])
    );
  end

  assign start_o     = start_q;
  assign start_idx_o = idx_q;
  assign busy_o      = busy_q;
  assign merr_o      = merr_q;
  assign irq_o       = (|(done_o & done_ie)) || (merr_q && merr_ie);

  // R3
  no_start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(abort_all) && busy_o);
  // R3
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(busy_o));
  // R7
  merr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && tx_err && !tx_ok && !merr_clr |=> merr_o);
endmodule

// File: tb/txs_sched_tb.sv
module txs_sched_tb;
  localparam int N = 3;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [N-1:0] wr_en = 0, wr_req = 0, rts_n = '1, rts_en = 0, done_clr = 0, done_ie = 0;
  logic [2*N-1:0] wr_prio = 0;
  logic abort_all = 0, one_shot = 0, bus_idle = 0, tx_ok = 0, tx_lost = 0, tx_err = 0;
  logic merr_clr = 0, merr_ie = 0;
  logic start_o, busy_o, merr_o, irq_o;
  logic [1:0] start_idx_o;
  logic [N-1:0] req_o, abtf_o, mloa_o, txerr_o, done_o;

  txs_sched u_dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  logic [N-1:0] m_req = 0, m_abtf = 0, m_mloa = 0, m_txerr = 0, m_done = 0, m_prev = '1;
  logic [1:0] m_prio [N];
  logic m_busy = 0, m_start = 0, m_merr = 0;
  int m_act = 0, m_idx = 0;
  logic [N-1:0] n_req, n_abtf, n_mloa, n_txerr, n_done;
  logic [1:0] n_prio [N];
  logic n_busy, n_start, n_merr;
  int n_act, n_idx;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // descending scan, strictly greater: larger index keeps equal priority
  function automatic int best_buf(input logic [N-1:0] r);
    int w = -1;
    for (int i = N - 1; i >= 0; i--)
      if (r[i] && (w < 0 || m_prio[i] > m_prio[w])) w = i;
    return w;
  endfunction

  task automatic model_next();
    int oc, w;
    n_req = m_req; n_abtf = m_abtf; n_mloa = m_mloa; n_txerr = m_txerr; n_done = m_done;
    n_busy = m_busy; n_act = m_act; n_idx = m_idx; n_start = 0; n_merr = m_merr;
    for (int i = 0; i < N; i++) n_prio[i] = m_prio[i];
    w = best_buf(m_req);
    if (bus_idle && !m_busy && !abort_all && w >= 0) begin
      n_busy = 1; n_act = w; n_idx = w; n_start = 1;
    end
    oc = !m_busy ? 0 : tx_ok ? 1 : tx_err ? 3 : tx_lost ? 2 : 0;
    for (int i = 0; i < N; i++) begin
      bit actv = m_busy && m_act == i;
      if (actv && oc == 1) begin n_req[i] = 0; n_done[i] = 1; end
      if (actv && oc >= 2) begin
        if (oc == 2) n_mloa[i] = 1; else n_txerr[i] = 1;
        if (one_shot || abort_all) begin n_req[i] = 0; n_abtf[i] = 1; end
      end
      if (abort_all && m_req[i] && !actv) begin n_req[i] = 0; n_abtf[i] = 1; end
      if (wr_en[i]) begin
        n_req[i] = wr_req[i]; n_prio[i] = wr_prio[2*i +: 2];
        if (wr_req[i]) begin n_abtf[i] = 0; n_mloa[i] = 0; n_txerr[i] = 0; end
      end
      if (rts_en[i] && m_prev[i] && !rts_n[i]) begin
        n_req[i] = 1; n_abtf[i] = 0; n_mloa[i] = 0; n_txerr[i] = 0;
      end
      if (done_clr[i]) n_done[i] = 0;
    end
    if (oc != 0) n_busy = 0;
    if (oc == 3) n_merr = 1;
    if (merr_clr) n_merr = 0;
  endtask

  task automatic tick();
    model_next();
    @(posedge clk); #1;
    m_req = n_req; m_abtf = n_abtf; m_mloa = n_mloa; m_txerr = n_txerr; m_done = n_done;
    m_busy = n_busy; m_act = n_act; m_idx = n_idx; m_start = n_start; m_merr = n_merr;
    m_prev = rts_n;
    for (int i = 0; i < N; i++) m_prio[i] = n_prio[i];
    wr_en = 0; bus_idle = 0; tx_ok = 0; tx_lost = 0; tx_err = 0; done_clr = 0; merr_clr = 0;
    chk("R1 start", start_o, m_start);
    if (m_start) chk("R1 start_idx", start_idx_o, m_idx);
    chk("R3 busy", busy_o, m_busy);
    chk("R4 req", req_o, m_req);
    chk("R9 abtf", abtf_o, m_abtf);
    chk("R6 mloa", mloa_o, m_mloa);
    chk("R7 txerr", txerr_o, m_txerr);
    chk("R5 done", done_o, m_done);
    chk("R7 merr", merr_o, m_merr);
    chk("R11 irq", irq_o, (|(m_done & done_ie)) || (m_merr && merr_ie));
  endtask

  task automatic wr(input int b, input bit r, input logic [1:0] p);
    wr_en[b] = 1; wr_req[b] = r; wr_prio[2*b +: 2] = p; tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 req", req_o, 0); chk("R12 busy", busy_o, 0);
    chk("R12 start", start_o, 0); chk("R12 irq", irq_o, 0);
    chk("R12 flags", {abtf_o, mloa_o, txerr_o, done_o, merr_o}, 0);

    // R1 highest value wins
    wr(0, 1, 1); wr(1, 1, 3); wr(2, 1, 2);
    bus_idle = 1; tick();
    chk("R1 pick", {start_o, start_idx_o}, {1'b1, 2'd1});
    tx_ok = 1; tick();
    chk("R5 ok", {req_o[1], done_o[1]}, 2'b01);
    chk("R11 gated", irq_o, 0);
    done_ie[1] = 1; tick();
    chk("R11 irq", irq_o, 1);

    // R2 tie goes to larger index; R6 retry; R7 error
    wr(0, 1, 2);
    bus_idle = 1; tick();
    chk("R2 tie", start_idx_o, 2);
    tx_lost = 1; tick();
    chk("R6 lost", {mloa_o[2], req_o[2]}, 2'b11);
    bus_idle = 1; tick();
    chk("R6 retry", {start_o, start_idx_o}, {1'b1, 2'd2});
    tx_err = 1; tick();
    chk("R7 err", {txerr_o[2], merr_o, req_o[2]}, 3'b111);

    // R10 plain clear
    wr(2, 0, 2);
    chk("R10 clear", {req_o[2], abtf_o[2]}, 2'b00);

    // R8 one-shot
    one_shot = 1; bus_idle = 1; tick();
    chk("R8 launch", start_idx_o, 0);
    tx_lost = 1; tick();
    chk("R8 oneshot", {req_o[0], abtf_o[0]}, 2'b01);
    one_shot = 0;

    // R9 global abort
    wr(0, 1, 0); wr(1, 1, 1);
    bus_idle = 1; tick();
    chk("R9 launch", start_idx_o, 1);
    abort_all = 1; tick();
    chk("R9 drop", {req_o[1:0], abtf_o[1:0]}, 4'b1001);
    wr(2, 1, 3); tick();
    bus_idle = 1; tick();
    chk("R3 no launch", start_o, 0);
    tx_lost = 1; tick();
    chk("R9 inflight", {req_o[1], abtf_o[1]}, 2'b01);
    abort_all = 0; tick();

    // R4 request pins and write set
    rts_en[2] = 1; rts_n[2] = 0; rts_n[1] = 0; tick();
    chk("R4 pin", {req_o[2], abtf_o[2]}, 2'b10);
    chk("R4 pin off", req_o[1], 0);
    wr(1, 1, 0);
    chk("R4 wr", {req_o[1], abtf_o[1], mloa_o[1]}, 3'b100);
    rts_n = '1; tick();

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 12;
      int b = $urandom % N;
      case (r)
        0, 1: begin wr_en[b] = 1; wr_req[b] = ($urandom % 4) != 0; wr_prio[2*b +: 2] = 2'($urandom); end
        2: rts_n[b] = ~rts_n[b];
        3: rts_en[b] = ~rts_en[b];
        4, 5, 6: bus_idle = 1;
        7, 8: begin
          int o = $urandom % 4;
          tx_ok = (o == 0); tx_lost = (o == 1); tx_err = (o >= 2);
          if ($urandom % 8 == 0) begin tx_ok = 1; tx_err = 1; end
        end
        9: begin done_clr = N'($urandom); merr_clr = $urandom % 2; end
        10: begin abort_all = ($urandom % 5) == 0; one_shot = $urandom % 2; end
        default: begin done_ie = N'($urandom); merr_ie = $urandom % 2; end
      endcase
      tick();
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule